// File: doc/BRIEF.md
# Serial-Peripheral Register Front End for a UART

This block is the host-facing register file of a small asynchronous serial port. A host talks to it over a 16-bit SPI slave link. The top two bits of every frame choose one of four operations: write configuration, read configuration, write transmit data, or read receive data. The block keeps the configuration, the interrupt masks and the request-to-send state. It hands transmit words to the serializer and pop and flush strobes to the receive FIFO. It also drives an active-low interrupt line that combines four maskable status sources.

All logic runs on one system clock. The SPI clock, chip select, MOSI and the clear-to-send pin pass through synchronizers, and their edges are found in the system clock domain. Nothing is committed until chip select rises after a complete 16-bit frame. A new serial format only reaches the serial engines once the transmitter reports idle. Mask bits take effect as soon as the last frame bit has been sampled.

Top module: `uart_spi_regfront`

## Requirements
- R1: A frame is 16 bits, most significant bit first. MOSI is taken on SCLK rising edges and MISO changes after SCLK falling edges. For every operation, MISO bit 15 is the receive-available input and bit 14 is the transmit-empty input, both sampled when chip select falls. A write frame returns zeros in bits 13..0.
- R2: Frame bits 15..14 select the operation: 2'b11 write config, 2'b01 read config, 2'b10 write data, 2'b00 read data.
- R3: If chip select rises before the 16th SCLK rising edge, the frame has no effect: no strobe, and no change to RTS, config or masks.
- R4: A read data frame returns zeros in bits 13..11. Bit 10 is FE/RA, bit 9 is 1 when cts_n is low, bit 8 is the received ninth bit, and bits 7..0 are the data. At chip select rise it gives one rx_pop pulse.
- R5: In a write data frame, bit 10 = 1 updates only the RTS state from bit 9. Bit 10 = 0 also gives one tx_load pulse with tx_word = bits 8..0. rts_n is the inverse of the stored RTS bit.
- R6: A write config frame gives one rx_flush pulse at chip select rise, clears the transmit-empty event and leaves RTS unchanged. Its fields form cfg_active = {bit13 fifo disable, bit12 shutdown request, bits 7..0}. This value reaches cfg_active only in a cycle where tx_idle is high.
- R7: Mask bits 11..8 of a write config frame ({transmit-empty, receive-available, ninth-bit, FE/RA}) take effect after the 16th SCLK rising edge, before chip select rises.
- R8: irq_n is low, one clock after its inputs, exactly when at least one of these holds: receive-available with its mask, the transmit-empty event with its mask, the ninth bit with its mask, or FE/RA with its mask.
- R9: The transmit-empty event is set when tx_empty rises. It is cleared at the commit of a read data frame or a write config frame.
- R10: A read config frame returns {R, T, fifo disable, shdn_stat input, masks[3:0], config bits 7..0} from the last written configuration. Its bit 0 sets test_en.
- R11: miso_oe is high exactly while cs_n is low.
- R12: After reset, cfg_active, the masks and test_en are 0, rts_n and irq_n are 1, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| miso_oe | output | 1 | Output enable for the MISO pad |
| rx_avail | input | 1 | Receive FIFO holds data |
| rx_word | input | 9 | Oldest receive word, ninth bit on top |
| rx_fe_ra | input | 1 | Framing error, or receive activity in shutdown |
| cts_n | input | 1 | Clear-to-send pin, active low |
| tx_empty | input | 1 | Transmit buffer empty |
| tx_idle | input | 1 | Transmitter has finished its frame |
| shdn_stat | input | 1 | Serial engines are in shutdown |
| tx_load | output | 1 | Strobe loading tx_word into the transmit buffer |
| tx_word | output | 9 | Transmit word, ninth bit on top |
| rx_pop | output | 1 | Strobe removing the oldest receive word |
| rx_flush | output | 1 | Strobe clearing receive state |
| cfg_active | output | 10 | Configuration in force |
| rts_n | output | 1 | Request-to-send pin, active low |
| test_en | output | 1 | Test mode request |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with the default two-stage synchronizers. The SPI clock half period is a few system clocks longer than the synchronizer plus edge-detect delay, so every MISO bit can be sampled before the next rising edge. The bench can also observe the interrupt line between the 16th SCLK edge and the chip select rise. That window shows the immediate mask update apart from the deferred commit. Holding tx_idle low across a write config shows the deferred configuration in isolation.

// File: rtl/uart_spi_pkg.sv
package uart_spi_pkg;

  localparam int FRAME_W = 16;
  localparam int WORD_W  = 9;
  localparam int CFG_W   = 10;
  localparam int MASK_W  = 4;

  typedef enum logic [1:0] {
    OP_RDATA = 2'b00,
    OP_RCFG  = 2'b01,
    OP_WDATA = 2'b10,
    OP_WCFG  = 2'b11
  } spi_op_e;

  // Receive-side reply word.
  function automatic logic [FRAME_W-1:0] pack_rdata(input logic r, input logic t,
      input logic fe, input logic cts_n, input logic [WORD_W-1:0] w);
    return {r, t, 3'b000, fe, ~cts_n, w};
  endfunction

  // Configuration readback word.
  function automatic logic [FRAME_W-1:0] pack_rcfg(input logic r, input logic t,
      input logic [CFG_W-1:0] c, input logic shdn, input logic [MASK_W-1:0] m);
    return {r, t, c[9], shdn, m, c[7:0]};
  endfunction

  // Config fields carried by a write-config frame.
  function automatic logic [CFG_W-1:0] cfg_of_frame(input logic [FRAME_W-1:0] f);
    return {f[13], f[12], f[7:0]};
  endfunction

  // Masks order: {tx-empty, rx-avail, ninth bit, fe/ra}.
  function automatic logic irq_any(input logic [MASK_W-1:0] m, input logic t_evt,
      input logic r, input logic par, input logic fe);
    return (m[3] & t_evt) | (m[2] & r) | (m[1] & par) | (m[0] & fe);
  endfunction

endpackage

// File: rtl/uart_spi_sync.sv
module uart_spi_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/uart_spi_shifter.sv
module uart_spi_shifter
  import uart_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] rd_word,
  input  logic [FRAME_W-1:0] cfg_word,
  output logic               miso,
  output logic               full_evt,
  output logic [FRAME_W-1:0] full_word,
  output logic               commit_evt,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic sclk_d, cs_d;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] rise_cnt, fall_cnt, fall_nxt;
  logic [FRAME_W-1:0] shreg, snap_rd, snap_cfg, out_word;
  logic [1:0] cmd_q;
  logic cmd_vld;
  logic [3:0] bidx;
  logic miso_q;

  assign cs_fall   = cs_d & ~cs_n_s;
  assign cs_rise   = ~cs_d & cs_n_s;
  assign sclk_rise = ~cs_n_s & sclk_s & ~sclk_d;
  assign sclk_fall = ~cs_n_s & ~sclk_s & sclk_d;

  assign full_evt   = sclk_rise && (rise_cnt == LAST - 1'b1);
  assign full_word  = {shreg[FRAME_W-2:0], mosi_s};
  assign commit_evt = cs_rise && (rise_cnt == LAST);
  assign frame_word = shreg;

  assign cmd_vld  = rise_cnt >= CNT_W'(2);
  assign fall_nxt = fall_cnt + 1'b1;
  assign bidx     = 4'(CNT_W'(FRAME_W - 1) - fall_nxt);

  always_comb begin
    out_word = {snap_rd[15:14], 14'b0};
    if (cmd_vld) begin
      case (spi_op_e'(cmd_q))
        OP_RDATA: out_word = snap_rd;
        OP_RCFG:  out_word = snap_cfg;
        default:  out_word = {snap_rd[15:14], 14'b0};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      rise_cnt <= '0;
      fall_cnt <= '0;
      shreg    <= '0;
      snap_rd  <= '0;
      snap_cfg <= '0;
      cmd_q    <= '0;
      miso_q   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      if (cs_fall) begin
        rise_cnt <= '0;
        fall_cnt <= '0;
        snap_rd  <= rd_word;
        snap_cfg <= cfg_word;
        miso_q   <= rd_word[FRAME_W-1];
      end else begin
        if (sclk_rise && rise_cnt < LAST) begin
          shreg    <= full_word;
          rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt == CNT_W'(1)) cmd_q <= {shreg[0], mosi_s};
        end
        if (sclk_fall) begin
          if (fall_cnt < LAST - 1'b1) begin
            fall_cnt <= fall_nxt;
            miso_q   <= out_word[bidx];
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  assign miso = miso_q;
endmodule

// File: rtl/uart_spi_regs.sv
module uart_spi_regs
  import uart_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_evt,
  input  logic [FRAME_W-1:0] full_word,
  input  logic               commit_evt,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               tx_idle,
  output logic [MASK_W-1:0]  masks,
  output logic [CFG_W-1:0]   cfg_written,
  output logic [CFG_W-1:0]   cfg_active,
  output logic               rts_bit,
  output logic               test_en,
  output logic               tx_load,
  output logic [WORD_W-1:0]  tx_word,
  output logic               rx_pop,
  output logic               rx_flush,
  output logic               evt_clr
);
  spi_op_e op;
  logic pend;
  logic unused_bits;

  assign op = spi_op_e'(frame_word[15:14]);
  assign evt_clr = commit_evt && (op == OP_RDATA || op == OP_WCFG);
  assign unused_bits = ^{full_word[13:12], full_word[7:0], frame_word[11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masks       <= '0;
      cfg_written <= '0;
      cfg_active  <= '0;
      pend        <= 1'b0;
      rts_bit     <= 1'b0;
      test_en     <= 1'b0;
      tx_load     <= 1'b0;
      tx_word     <= '0;
      rx_pop      <= 1'b0;
      rx_flush    <= 1'b0;
    end else begin
      tx_load  <= 1'b0;
      rx_pop   <= 1'b0;
      rx_flush <= 1'b0;
      if (full_evt && spi_op_e'(full_word[15:14]) == OP_WCFG)
        masks <= full_word[11:8];
      if (pend && tx_idle) begin
        cfg_active <= cfg_written;
        pend       <= 1'b0;
      end
      if (commit_evt) begin
        case (op)
          OP_WCFG: begin
            cfg_written <= cfg_of_frame(frame_word);
            pend        <= 1'b1;
            rx_flush    <= 1'b1;
          end
          OP_WDATA: begin
            rts_bit <= frame_word[9];
            if (!frame_word[10]) begin
              tx_load <= 1'b1;
              tx_word <= frame_word[8:0];
            end
          end
          OP_RCFG:  test_en <= frame_word[0];
          default:  rx_pop  <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_spi_irq.sv
module uart_spi_irq
  import uart_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_empty,
  input  logic              evt_clr,
  input  logic              rx_avail,
  input  logic              rx_par,
  input  logic              rx_fe_ra,
  input  logic [MASK_W-1:0] masks,
  output logic              t_evt,
  output logic              irq_n
);
  logic tx_empty_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty_d <= 1'b1;
      t_evt      <= 1'b0;
      irq_n      <= 1'b1;
    end else begin
      tx_empty_d <= tx_empty;
      if (tx_empty && !tx_empty_d) t_evt <= 1'b1;
      else if (evt_clr)            t_evt <= 1'b0;
      irq_n <= ~irq_any(masks, t_evt, rx_avail, rx_par, rx_fe_ra);
    end
  end
endmodule

// File: rtl/uart_spi_regfront.sv
module uart_spi_regfront
  import uart_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              rx_avail,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_fe_ra,
  input  logic              cts_n,
  input  logic              tx_empty,
  input  logic              tx_idle,
  input  logic              shdn_stat,
  output logic              tx_load,
  output logic [WORD_W-1:0] tx_word,
  output logic              rx_pop,
  output logic              rx_flush,
  output logic [CFG_W-1:0]  cfg_active,
  output logic              rts_n,
  output logic              test_en,
  output logic              irq_n
);
  logic [3:0] pins_s;
  logic sclk_s, cs_n_s, mosi_s, cts_n_s;
  logic full_evt, commit_evt, evt_clr, rts_bit, t_evt;
  logic [FRAME_W-1:0] full_word, frame_word, rd_word, cfg_word;
  logic [MASK_W-1:0] masks;
  logic [CFG_W-1:0] cfg_written;

  uart_spi_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, cts_n, mosi}), .q(pins_s)
  );
  assign {cs_n_s, sclk_s, cts_n_s, mosi_s} = pins_s;

  assign rd_word  = pack_rdata(rx_avail, tx_empty, rx_fe_ra, cts_n_s, rx_word);
  assign cfg_word = pack_rcfg(rx_avail, tx_empty, cfg_written, shdn_stat, masks);

  uart_spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .rd_word(rd_word), .cfg_word(cfg_word), .miso(miso),
    .full_evt(full_evt), .full_word(full_word),
    .commit_evt(commit_evt), .frame_word(frame_word)
  );

  uart_spi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .full_evt(full_evt), .full_word(full_word),
    .commit_evt(commit_evt), .frame_word(frame_word), .tx_idle(tx_idle),
    .masks(masks), .cfg_written(cfg_written), .cfg_active(cfg_active),
    .rts_bit(rts_bit), .test_en(test_en), .tx_load(tx_load), .tx_word(tx_word),
    .rx_pop(rx_pop), .rx_flush(rx_flush), .evt_clr(evt_clr)
  );

  uart_spi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .evt_clr(evt_clr),
    .rx_avail(rx_avail), .rx_par(rx_word[WORD_W-1]), .rx_fe_ra(rx_fe_ra),
    .masks(masks), .t_evt(t_evt), .irq_n(irq_n)
  );

  assign miso_oe = ~cs_n;
  assign rts_n   = ~rts_bit;
endmodule

// File: rtl/uart_spi_regfront_chk.sv
module uart_spi_regfront_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_load,
  input logic       rx_pop,
  input logic       rx_flush,
  input logic       commit_evt,
  input logic       full_evt,
  input logic       tx_idle,
  input logic       tx_empty,
  input logic       t_evt,
  input logic       rts_n,
  input logic       irq_n,
  input logic [3:0] masks,
  input logic [9:0] cfg_active
);
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_load, rx_pop, rx_flush}));

  assert_load_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(commit_evt));

  assert_rts_moves_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rts_n) |-> $past(commit_evt));

  assert_cfg_waits_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_active) |-> $past(tx_idle));

  assert_mask_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(masks) |-> $past(full_evt));

  assert_quiet_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (masks == 4'b0) |=> irq_n);

  assert_event_from_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_evt) |-> $past(tx_empty));

  assert_pop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop);
endmodule

bind uart_spi_regfront uart_spi_regfront_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .rx_pop(rx_pop), .rx_flush(rx_flush),
  .commit_evt(commit_evt), .full_evt(full_evt), .tx_idle(tx_idle), .tx_empty(tx_empty),
  .t_evt(t_evt), .rts_n(rts_n), .irq_n(irq_n), .masks(masks), .cfg_active(cfg_active)
);

// File: tb/uart_spi_regfront_tb.sv
module uart_spi_regfront_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 50000;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe;
  logic rx_avail = 0, rx_fe_ra = 0, cts_n = 1, tx_empty = 1, tx_idle = 1, shdn_stat = 0;
  logic [8:0] rx_word = '0;
  logic tx_load, rx_pop, rx_flush, rts_n, test_en, irq_n;
  logic [8:0] tx_word;
  logic [9:0] cfg_active;

  int checks = 0, fails = 0, cyc = 0;
  int loads = 0, pops = 0, flushes = 0;
  logic [8:0] last_tx = '0;
  logic [15:0] rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_spi_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe), .rx_avail(rx_avail), .rx_word(rx_word), .rx_fe_ra(rx_fe_ra),
    .cts_n(cts_n), .tx_empty(tx_empty), .tx_idle(tx_idle), .shdn_stat(shdn_stat),
    .tx_load(tx_load), .tx_word(tx_word), .rx_pop(rx_pop), .rx_flush(rx_flush),
    .cfg_active(cfg_active), .rts_n(rts_n), .test_en(test_en), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    if (tx_load) begin loads <= loads + 1; last_tx <= tx_word; end
    if (rx_pop) pops <= pops + 1;
    if (rx_flush) flushes <= flushes + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog R1 act=%0d exp<%0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic spi_shift(input logic [15:0] w, input int n, output logic [15:0] r);
    r = '0;
    @(negedge clk); cs_n = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      r[15-i] = miso;
      mosi = w[15-i];
      repeat (2) @(negedge clk); sclk = 1;
      repeat (6) @(negedge clk); sclk = 0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic spi_end();
    @(negedge clk); cs_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic spi_frame(input logic [15:0] w, output logic [15:0] r);
    spi_shift(w, 16, r);
    spi_end();
  endtask

  // {rx_avail, tx_empty, fe, cts_n, rx_word[8:0], expected reply}
  typedef struct packed {
    logic ra; logic te; logic fe; logic cn; logic [8:0] w; logic [15:0] exp;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 9'h1A5, 16'hC3A5},
    '{1'b0, 1'b0, 1'b1, 1'b1, 9'h000, 16'h0400},
    '{1'b1, 1'b0, 1'b0, 1'b1, 9'h07E, 16'h807E},
    '{1'b0, 1'b1, 1'b1, 1'b0, 9'h100, 16'h4700}
  };

  initial begin
    int p0, l0, f0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 irq_n", irq_n, 1); chk("R12 rts_n", rts_n, 1);
    chk("R12 cfg", cfg_active, 0); chk("R12 test_en", test_en, 0);
    chk("R12 strobes", {tx_load, rx_pop, rx_flush}, 0);
    chk("R11 oe idle", miso_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R4 / R1 read data table
    for (int k = 0; k < 4; k++) begin
      rx_avail = VECS[k].ra; tx_empty = VECS[k].te; rx_fe_ra = VECS[k].fe;
      cts_n = VECS[k].cn; rx_word = VECS[k].w;
      repeat (6) @(negedge clk);
      p0 = pops;
      spi_frame(16'h0000, rx);
      chk("R4 R1 read data word", rx, VECS[k].exp);
      chk("R4 rx_pop once", pops - p0, 1);
    end

    // R5 write data, TE=0; R1 reply of a write frame
    rx_avail = 1; tx_empty = 0; rx_word = '0; rx_fe_ra = 0; cts_n = 1;
    repeat (6) @(negedge clk);
    l0 = loads;
    spi_shift(16'h835A, 16, rx);
    chk("R11 oe active", miso_oe, 1);
    spi_end();
    chk("R1 write reply", rx, 16'h8000);
    chk("R5 tx_load once", loads - l0, 1);
    chk("R5 tx_word", last_tx, 9'h15A);
    chk("R5 rts_n low", rts_n, 0);

    // R5 TE=1 only RTS
    l0 = loads;
    spi_frame(16'h84FF, rx);
    chk("R5 TE no load", loads - l0, 0);
    chk("R5 TE rts_n high", rts_n, 1);

    // R3 short frame
    l0 = loads;
    spi_shift(16'h8200, 10, rx);
    spi_end();
    chk("R3 short no load", loads - l0, 0);
    chk("R3 short rts unchanged", rts_n, 1);
    spi_shift(16'hC400, 12, rx);
    spi_end();
    chk("R3 short wcfg no flush", flushes, 0);

    // R6 write config deferred until tx_idle
    rx_avail = 0; tx_empty = 1; tx_idle = 0;
    repeat (6) @(negedge clk);
    f0 = flushes;
    spi_frame(16'hE035, rx);
    chk("R6 flush once", flushes - f0, 1);
    chk("R6 cfg held while busy", cfg_active, 0);
    chk("R6 rts unchanged", rts_n, 1);
    tx_idle = 1;
    repeat (4) @(negedge clk);
    chk("R6 cfg applied", cfg_active, 10'h235);

    // R10 read config and test mode
    shdn_stat = 1;
    repeat (4) @(negedge clk);
    spi_frame(16'h4001, rx);
    chk("R10 read config", rx, 16'h7035);
    chk("R10 test_en", test_en, 1);
    shdn_stat = 0;

    // R7 mask effective before chip select rises
    rx_avail = 1;
    repeat (4) @(negedge clk);
    chk("R8 unmasked quiet", irq_n, 1);
    spi_shift(16'hE435, 16, rx);
    repeat (4) @(negedge clk);
    chk("R7 mask before commit", irq_n, 0);
    spi_end();
    rx_avail = 0;
    repeat (4) @(negedge clk);
    chk("R8 source gone", irq_n, 1);

    // R9 transmit-empty event with its mask
    spi_frame(16'hE835, rx);
    chk("R9 cleared by wcfg", irq_n, 1);
    tx_empty = 0; repeat (3) @(negedge clk);
    tx_empty = 1; repeat (4) @(negedge clk);
    chk("R9 event raises irq", irq_n, 0);
    spi_frame(16'h0000, rx);
    chk("R9 read data clears event", irq_n, 1);

    // R8 fe/ra and ninth bit sources
    spi_frame(16'hE135, rx);
    rx_fe_ra = 1; repeat (4) @(negedge clk);
    chk("R8 fe masked", irq_n, 0);
    rx_fe_ra = 0; repeat (4) @(negedge clk);
    chk("R8 fe cleared", irq_n, 1);
    spi_frame(16'hE235, rx);
    rx_word = 9'h100; repeat (4) @(negedge clk);
    chk("R8 ninth bit masked", irq_n, 0);
    chk("R2 cfg kept", cfg_active, 10'h235);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule